// File: doc/BRIEF.md
# USB Host Controller Command, Status and Interrupt Registers

This block is the register front end of a legacy full-speed USB host controller. Software reaches it through a 32-byte I/O window that accepts byte, word and dword accesses. Through that window it starts and stops the controller, resets it, and enables interrupt sources. It also reads and acknowledges status, programs the frame list base address and the SOF timing byte, and reads or presets the 11-bit frame counter.

A programmable divider produces a frame tick, one per millisecond at the default setting. Each tick advances the frame counter and posts the interrupt causes that the schedule logic reported during the frame just ended. Two hidden cause bits sit behind the single visible status interrupt bit: one for transfer completion and one for short packets. Software can therefore enable the two sources separately. One level-sensitive interrupt output merges every enabled source.

Top module: `usbh_ctl_regs`

## Requirements
- R1: After reset the command word, status word, enable word, frame number and base address all read 0, and the SOF timing byte (byte at 0x0C) reads 64. Word registers sit at command 0x00, status 0x02, enable 0x04 (bits 3:0 held, upper bits read 0) and frame number 0x06. The dword base register sits at 0x08.
- R2: Only address bits 4:0 are decoded. Unimplemented byte reads return 0xFF, unimplemented word reads return 0xFF7F, and unimplemented dword reads or reads with size code 3 return 0xFFFFFFFF. Size codes are 0 byte, 1 word, 2 dword.
- R3: A base address write keeps bits 31:12, and bits 11:0 read as zero. A byte write at 0x0C stores the SOF timing byte.
- R4: Writing command bit 0 (run) as 1 while it was 0 clears the halted status bit (bit 5) and restarts the tick divider. Writing bit 0 as 0 sets halted on the next cycle.
- R5: While running, frame_tick pulses once every TICK_DIV cycles and the frame number then increments modulo 2048. A tick that finds run clear emits no frame_tick and stops the divider, and the frame number holds.
- R6: A word write to 0x06 loads bits 10:0 into the frame number only while halted is set. Otherwise the write is ignored.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A set event arriving in the same cycle wins.
- R8: Pulses on cause_in (bit 0 completion, bit 1 short packet) accumulate during a frame. At the next frame_tick a nonzero accumulated mask is ORed into the hidden causes and sets status bit 0. A cause that is not yet posted does not show in status.
- R9: irq is high when any of these holds: completion cause with enable bit 2, short-packet cause with enable bit 3, status bit 1 with enable bit 0, status bit 2 with enable bit 1, status bit 3, or status bit 4.
- R10: Writing 1 to status bit 0 also clears both hidden cause bits, and irq drops if no other source is active.
- R11: A command write with bit 1 (host reset) or bit 2 (global reset) set does not store the written value. It returns every register to its reset value and stops the tick divider. A global reset also pulses bus_reset_req for exactly one cycle.
- R12: When command bit 3 (global-suspend enable) is set, a resume_evt pulse sets command bit 4 and status bit 2 (resume detect). When bit 3 is clear, resume_evt has no effect.
- R13: Pulses on err_evt, hse_evt and perr_evt set status bits 1, 3 and 4 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe for one cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_size | input | 2 | 0 byte, 1 word, 2 dword |
| acc_addr | input | ADDR_W | Access address; only bits 4:0 decoded |
| acc_wdata | input | 32 | Write data, right-aligned |
| rd_data | output | 32 | Read data for the current address and size (combinational) |
| cause_in | input | 2 | Per-frame interrupt cause pulses (bit 0 completion, bit 1 short packet) |
| err_evt | input | 1 | Transfer error event |
| hse_evt | input | 1 | Host system error event |
| perr_evt | input | 1 | Process error event |
| resume_evt | input | 1 | Remote resume event |
| frame_tick | output | 1 | One-cycle pulse at each frame boundary while running |
| frame_num | output | 11 | Current frame number |
| bus_reset_req | output | 1 | One-cycle request to reset every connected port |
| irq | output | 1 | Level interrupt output |

## Verification
A wrong hidden cause bit shows at irq one cycle after the enable word changes. Most other faults also show at the ports within one cycle. A stuck halted bit shows as an accepted or refused frame number write, which is visible on the next read. A divider off by one shows as a frame_tick spacing other than TICK_DIV and as a frame number that drifts over two frames. A posting error appears exactly one frame late or early, so the bench samples status on each side of the tick.

// File: rtl/usbh_pkg.sv
package usbh_pkg;

  // command bit positions
  localparam int CMD_RUN  = 0;
  localparam int CMD_HRST = 1;
  localparam int CMD_GRST = 2;
  localparam int CMD_SUSP = 3;
  localparam int CMD_FRES = 4;

  // status bit positions
  localparam int ST_INT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_RES  = 2;
  localparam int ST_HSE  = 3;
  localparam int ST_PERR = 4;
  localparam int ST_HALT = 5;

  localparam int STS_W   = 6;
  localparam int IEN_W   = 4;
  localparam int FNUM_W  = 11;
  localparam int CAUSE_W = 2;

  // register offsets inside the 32-byte window
  localparam logic [4:0] OFS_CMD  = 5'h00;
  localparam logic [4:0] OFS_STS  = 5'h02;
  localparam logic [4:0] OFS_IEN  = 5'h04;
  localparam logic [4:0] OFS_FNUM = 5'h06;
  localparam logic [4:0] OFS_BASE = 5'h08;
  localparam logic [4:0] OFS_SOF  = 5'h0C;

  localparam logic [7:0] SOF_RESET = 8'd64;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic cmd;
    logic sts;
    logic ien;
    logic fnum;
    logic base;
    logic sof;
  } wr_sel_t;

  function automatic logic [FNUM_W-1:0] frame_next(input logic [FNUM_W-1:0] f);
    return f + 1'b1;
  endfunction

  function automatic logic [31:0] base_keep(input logic [31:0] v);
    return {v[31:12], 12'h000};
  endfunction

  function automatic logic irq_level(input logic [CAUSE_W-1:0] cause,
                                     input logic [STS_W-1:0]   sts,
                                     input logic [IEN_W-1:0]   ien);
    return (cause[0] & ien[2]) | (cause[1] & ien[3]) |
           (sts[ST_ERR] & ien[0]) | (sts[ST_RES] & ien[1]) |
           sts[ST_HSE] | sts[ST_PERR];
  endfunction

endpackage

// File: rtl/usbh_decode.sv
module usbh_decode
  import usbh_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [15:0]       cmd_q,
  input  logic [STS_W-1:0]  sts_q,
  input  logic [IEN_W-1:0]  ien_q,
  input  logic [FNUM_W-1:0] fnum_q,
  input  logic [31:0]       base_q,
  input  logic [7:0]        sof_q,
  output wr_sel_t           wsel,
  output logic [31:0]       rd_data
);

  logic [4:0] ofs;
  acc_size_e  sz;
  logic       wr;

  assign ofs = acc_addr[4:0];
  assign sz  = acc_size_e'(acc_size);
  assign wr  = acc_valid & acc_write;

  generate
    if (ADDR_W > 5) begin : g_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^acc_addr[ADDR_W-1:5];
    end
  endgenerate

  always_comb begin
    wsel      = '0;
    wsel.cmd  = wr && sz == SZ_WORD  && ofs == OFS_CMD;
    wsel.sts  = wr && sz == SZ_WORD  && ofs == OFS_STS;
    wsel.ien  = wr && sz == SZ_WORD  && ofs == OFS_IEN;
    wsel.fnum = wr && sz == SZ_WORD  && ofs == OFS_FNUM;
    wsel.base = wr && sz == SZ_DWORD && ofs == OFS_BASE;
    wsel.sof  = wr && sz == SZ_BYTE  && ofs == OFS_SOF;
  end

  always_comb begin
    rd_data = 32'hFFFF_FFFF;
    case (sz)
      SZ_BYTE:  rd_data = (ofs == OFS_SOF) ? {24'h0, sof_q} : 32'h0000_00FF;
      SZ_WORD: begin
        case (ofs)
          OFS_CMD:  rd_data = {16'h0, cmd_q};
          OFS_STS:  rd_data = {{(32-STS_W){1'b0}}, sts_q};
          OFS_IEN:  rd_data = {{(32-IEN_W){1'b0}}, ien_q};
          OFS_FNUM: rd_data = {{(32-FNUM_W){1'b0}}, fnum_q};
          default:  rd_data = 32'h0000_FF7F;
        endcase
      end
      SZ_DWORD: rd_data = (ofs == OFS_BASE) ? base_q : 32'hFFFF_FFFF;
      default:  rd_data = 32'hFFFF_FFFF;
    endcase
  end

endmodule

// File: rtl/usbh_tick_gen.sv
module usbh_tick_gen #(
  parameter int TICK_DIV = 48000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic kill,
  input  logic run,
  output logic tick_fire,
  output logic active
);

  localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_fire = active && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (kill) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt_q  <= '0;
    end else if (active) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        if (!run) active <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/usbh_status.sv
module usbh_status
  import usbh_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_reset,
  input  logic               wr_sts,
  input  logic [STS_W-1:0]   wdata,
  input  logic               set_halt,
  input  logic               clr_halt,
  input  logic               ev_err,
  input  logic               ev_res,
  input  logic               ev_hse,
  input  logic               ev_perr,
  input  logic               post,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic [IEN_W-1:0]   ien,
  output logic [STS_W-1:0]   sts_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [CAUSE_W-1:0] pend_q,
  output logic               irq
);

  logic [STS_W-1:0]   sts_d;
  logic [CAUSE_W-1:0] cause_d;
  logic [CAUSE_W-1:0] pend_d;
  logic               post_hit;

  assign post_hit = post && (pend_q != '0);

  always_comb begin
    sts_d = sts_q;
    if (wr_sts) sts_d = sts_q & ~wdata;
    if (ev_err)   sts_d[ST_ERR]  = 1'b1;
    if (ev_res)   sts_d[ST_RES]  = 1'b1;
    if (ev_hse)   sts_d[ST_HSE]  = 1'b1;
    if (ev_perr)  sts_d[ST_PERR] = 1'b1;
    if (post_hit) sts_d[ST_INT]  = 1'b1;
    if (set_halt) sts_d[ST_HALT] = 1'b1;
    if (clr_halt) sts_d[ST_HALT] = 1'b0;
  end

  always_comb begin
    cause_d = cause_q;
    if (wr_sts && wdata[ST_INT]) cause_d = '0;
    if (post_hit) cause_d = cause_d | pend_q;
  end

  always_comb begin
    if (post) pend_d = cause_in;
    else      pend_d = pend_q | cause_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q   <= '0;
      cause_q <= '0;
      pend_q  <= '0;
    end else if (ctl_reset) begin
      sts_q   <= '0;
      cause_q <= '0;
      pend_q  <= '0;
    end else begin
      sts_q   <= sts_d;
      cause_q <= cause_d;
      pend_q  <= pend_d;
    end
  end

  assign irq = irq_level(cause_q, sts_q, ien);

endmodule

// File: rtl/usbh_ctl_regs.sv
module usbh_ctl_regs
  import usbh_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int TICK_DIV = 48000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       rd_data,
  input  logic [1:0]        cause_in,
  input  logic              err_evt,
  input  logic              hse_evt,
  input  logic              perr_evt,
  input  logic              resume_evt,
  output logic              frame_tick,
  output logic [10:0]       frame_num,
  output logic              bus_reset_req,
  output logic              irq
);

  logic [15:0]        cmd_q;
  logic [IEN_W-1:0]   ien_q;
  logic [FNUM_W-1:0]  fnum_q;
  logic [31:0]        base_q;
  logic [7:0]         sof_q;
  logic [STS_W-1:0]   sts_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [CAUSE_W-1:0] pend_q;
  logic               bus_rst_q;
  wr_sel_t            wsel;

  // named internal events
  logic run_rise, run_drop, grst_hit, hrst_hit, ctl_reset;
  logic tick_fire, tick_active, stop_tick;
  logic set_halt, clr_halt, resume_ok;

  assign run_rise  = wsel.cmd &  acc_wdata[CMD_RUN] & ~cmd_q[CMD_RUN];
  assign run_drop  = wsel.cmd & ~acc_wdata[CMD_RUN];
  assign grst_hit  = wsel.cmd &  acc_wdata[CMD_GRST];
  assign hrst_hit  = wsel.cmd &  acc_wdata[CMD_HRST];
  assign ctl_reset = grst_hit | hrst_hit;

  assign frame_tick = tick_fire &  cmd_q[CMD_RUN];
  assign stop_tick  = tick_fire & ~cmd_q[CMD_RUN];
  assign clr_halt   = run_rise;
  assign set_halt   = (run_drop | stop_tick) & ~run_rise;
  assign resume_ok  = resume_evt & cmd_q[CMD_SUSP];

  usbh_decode #(.ADDR_W(ADDR_W)) u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_size  (acc_size),
    .acc_addr  (acc_addr),
    .cmd_q     (cmd_q),
    .sts_q     (sts_q),
    .ien_q     (ien_q),
    .fnum_q    (fnum_q),
    .base_q    (base_q),
    .sof_q     (sof_q),
    .wsel      (wsel),
    .rd_data   (rd_data)
  );

  usbh_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (run_rise),
    .kill      (ctl_reset),
    .run       (cmd_q[CMD_RUN]),
    .tick_fire (tick_fire),
    .active    (tick_active)
  );

  usbh_status u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_reset (ctl_reset),
    .wr_sts    (wsel.sts),
    .wdata     (acc_wdata[STS_W-1:0]),
    .set_halt  (set_halt),
    .clr_halt  (clr_halt),
    .ev_err    (err_evt),
    .ev_res    (resume_ok),
    .ev_hse    (hse_evt),
    .ev_perr   (perr_evt),
    .post      (frame_tick),
    .cause_in  (cause_in),
    .ien       (ien_q),
    .sts_q     (sts_q),
    .cause_q   (cause_q),
    .pend_q    (pend_q),
    .irq       (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      ien_q     <= '0;
      fnum_q    <= '0;
      base_q    <= '0;
      sof_q     <= SOF_RESET;
      bus_rst_q <= 1'b0;
    end else begin
      bus_rst_q <= grst_hit;
      if (ctl_reset) begin
        cmd_q  <= '0;
        ien_q  <= '0;
        fnum_q <= '0;
        base_q <= '0;
        sof_q  <= SOF_RESET;
      end else begin
        if (wsel.cmd) cmd_q <= acc_wdata[15:0];
        if (resume_ok) cmd_q[CMD_FRES] <= 1'b1;
        if (wsel.ien) ien_q <= acc_wdata[IEN_W-1:0];
        if (wsel.base) base_q <= base_keep(acc_wdata);
        if (wsel.sof) sof_q <= acc_wdata[7:0];
        if (frame_tick) fnum_q <= frame_next(fnum_q);
        else if (wsel.fnum && sts_q[ST_HALT]) fnum_q <= acc_wdata[FNUM_W-1:0];
      end
    end
  end

  assign frame_num     = fnum_q;
  assign bus_reset_req = bus_rst_q;

endmodule

// File: rtl/usbh_ctl_regs_chk.sv
module usbh_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stop_tick,
  input logic        run_rise,
  input logic        run_drop,
  input logic        frame_tick,
  input logic        ctl_reset,
  input logic        grst_hit,
  input logic        wr_sts,
  input logic [31:0] wdata,
  input logic        err_evt,
  input logic [5:0]  sts_q,
  input logic [1:0]  pend_q,
  input logic [10:0] fnum_q,
  input logic [15:0] cmd_q,
  input logic [3:0]  ien_q,
  input logic        bus_reset_req,
  input logic        irq
);

  // R4: stop request reaches the halted bit
  p_halt_on_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_drop && !ctl_reset |=> sts_q[5]);

  // R5: idle tick halts
  p_halt_on_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_tick && !run_rise && !ctl_reset |=> sts_q[5]);

  // R5: frame number advances by one, wrapping at 2048
  p_frame_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && !ctl_reset |=> fnum_q == 11'($past(fnum_q) + 11'd1));

  // R6: frame number cannot change while not halted except by a tick or reset
  p_fnum_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_q[5] && !frame_tick && !ctl_reset |=> $stable(fnum_q));

  // R7: write-one-to-clear on the error bit
  p_w1c_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts && wdata[1] && !err_evt && !ctl_reset |=> !sts_q[1]);

  // R8: nonzero pending causes post at the tick
  p_post_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && (pend_q != 2'b00) && !ctl_reset |=> sts_q[0]);

  // R9: system errors force the interrupt line
  p_hse_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[3] || sts_q[4] |-> irq);

  // R11: a reset write leaves command and enable cleared
  p_reset_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> cmd_q == 16'h0 && ien_q == 4'h0 && fnum_q == 11'h0);

  // R11: global reset requests a bus reset next cycle
  p_bus_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    grst_hit |=> bus_reset_req);

endmodule

bind usbh_ctl_regs usbh_ctl_regs_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stop_tick     (stop_tick),
  .run_rise      (run_rise),
  .run_drop      (run_drop),
  .frame_tick    (frame_tick),
  .ctl_reset     (ctl_reset),
  .grst_hit      (grst_hit),
  .wr_sts        (wsel.sts),
  .wdata         (acc_wdata),
  .err_evt       (err_evt),
  .sts_q         (sts_q),
  .pend_q        (pend_q),
  .fnum_q        (fnum_q),
  .cmd_q         (cmd_q),
  .ien_q         (ien_q),
  .bus_reset_req (bus_reset_req),
  .irq           (irq)
);

// File: tb/usbh_ctl_regs_tb.sv
module usbh_ctl_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_size = 2'd1;
  logic [15:0] acc_addr = 16'h0;
  logic [31:0] acc_wdata = 32'h0;
  logic [31:0] rd_data;
  logic [1:0]  cause_in = 2'b00;
  logic        err_evt = 1'b0, hse_evt = 1'b0, perr_evt = 1'b0, resume_evt = 1'b0;
  logic        frame_tick;
  logic [10:0] frame_num;
  logic        bus_reset_req;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbh_ctl_regs #(.ADDR_W(16), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .cause_in(cause_in), .err_evt(err_evt), .hse_evt(hse_evt),
    .perr_evt(perr_evt), .resume_evt(resume_evt),
    .frame_tick(frame_tick), .frame_num(frame_num),
    .bus_reset_req(bus_reset_req), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_size = sz; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [15:0] a, output logic [31:0] d);
    acc_size = sz; acc_addr = a; acc_write = 1'b0;
    #1;
    d = rd_data;
  endtask

  task automatic rdchk(input string req, input logic [1:0] sz, input logic [15:0] a,
                       input logic [31:0] exp);
    logic [31:0] v;
    rd(sz, a, v);
    chk(req, v, exp);
  endtask

  task automatic wait_tick();
    int guard = 0;
    @(negedge clk);
    while (frame_tick !== 1'b1 && guard < 4*DIV) begin
      @(negedge clk);
      guard++;
    end
    #1;
  endtask

  task automatic pulse_cause(input logic [1:0] c);
    @(negedge clk); cause_in = c;
    @(negedge clk); cause_in = 2'b00;
    #1;
  endtask

  task automatic t_reset();
    rdchk("R1 cmd", 2'd1, 16'h00, 32'h0);
    rdchk("R1 sts", 2'd1, 16'h02, 32'h0);
    rdchk("R1 ien", 2'd1, 16'h04, 32'h0);
    rdchk("R1 fnum", 2'd1, 16'h06, 32'h0);
    rdchk("R1 base", 2'd2, 16'h08, 32'h0);
    rdchk("R1 sof", 2'd0, 16'h0C, 32'd64);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_unimpl();
    rdchk("R2 byte", 2'd0, 16'h00, 32'hFF);
    rdchk("R2 word", 2'd1, 16'h08, 32'hFF7F);
    rdchk("R2 word port", 2'd1, 16'h12, 32'hFF7F);
    rdchk("R2 dword", 2'd2, 16'h00, 32'hFFFFFFFF);
    rdchk("R2 size3", 2'd3, 16'h08, 32'hFFFFFFFF);
    wr(2'd1, 16'h0044, 32'h000F);
    rdchk("R2 alias", 2'd1, 16'h04, 32'hF);
    wr(2'd1, 16'h0004, 32'h0000);
  endtask

  task automatic t_base();
    wr(2'd2, 16'h08, 32'hDEADBEEF);
    rdchk("R3 base", 2'd2, 16'h08, 32'hDEADB000);
    wr(2'd0, 16'h0C, 32'h2A);
    rdchk("R3 sof", 2'd0, 16'h0C, 32'h2A);
  endtask

  task automatic t_halted_fnum();
    wr(2'd1, 16'h00, 32'h0000);
    rdchk("R4 halt set", 2'd1, 16'h02, 32'h20);
    wr(2'd1, 16'h06, 32'hFFFE);
    rdchk("R6 fnum load", 2'd1, 16'h06, 32'h7FE);
  endtask

  task automatic t_run_wrap();
    int n;
    wr(2'd1, 16'h00, 32'h0001);
    rdchk("R4 halt clear", 2'd1, 16'h02, 32'h00);
    wait_tick();
    @(negedge clk); #1;
    chk("R5 advance", {21'h0, frame_num}, 32'h7FF);
    n = 1;
    while (frame_tick !== 1'b1 && n < 4*DIV) begin
      @(negedge clk); #1;
      n++;
    end
    chk("R5 period", n, DIV);
    @(negedge clk); #1;
    chk("R5 wrap", {21'h0, frame_num}, 32'h000);
    wr(2'd1, 16'h06, 32'h0123);
    rdchk("R6 ignored running", 2'd1, 16'h06, 32'h000);
  endtask

  task automatic t_causes();
    wait_tick();
    wr(2'd1, 16'h04, 32'h4);
    pulse_cause(2'b01);
    rdchk("R8 not yet posted", 2'd1, 16'h02, 32'h00);
    chk("R8 irq before post", {31'h0, irq}, 32'h0);
    wait_tick();
    @(negedge clk); #1;
    rdchk("R8 posted", 2'd1, 16'h02, 32'h01);
    chk("R9 completion irq", {31'h0, irq}, 32'h1);
    wr(2'd1, 16'h02, 32'h01);
    rdchk("R7 int clear", 2'd1, 16'h02, 32'h00);
    chk("R10 irq drop", {31'h0, irq}, 32'h0);
    pulse_cause(2'b10);
    wait_tick();
    @(negedge clk); #1;
    rdchk("R8 short posted", 2'd1, 16'h02, 32'h01);
    chk("R9 short gated", {31'h0, irq}, 32'h0);
    wr(2'd1, 16'h04, 32'h8);
    chk("R9 short enabled", {31'h0, irq}, 32'h1);
    wr(2'd1, 16'h02, 32'h01);
    chk("R10 short cleared", {31'h0, irq}, 32'h0);
    wr(2'd1, 16'h04, 32'h0);
  endtask

  task automatic t_events();
    @(negedge clk); err_evt = 1'b1; @(negedge clk); err_evt = 1'b0; #1;
    rdchk("R13 err", 2'd1, 16'h02, 32'h02);
    chk("R9 err gated", {31'h0, irq}, 32'h0);
    wr(2'd1, 16'h04, 32'h1);
    chk("R9 err enabled", {31'h0, irq}, 32'h1);
    wr(2'd1, 16'h02, 32'h02);
    chk("R7 err clear irq", {31'h0, irq}, 32'h0);
    wr(2'd1, 16'h04, 32'h0);
    @(negedge clk); hse_evt = 1'b1; @(negedge clk); hse_evt = 1'b0; #1;
    rdchk("R13 hse", 2'd1, 16'h02, 32'h08);
    chk("R9 hse unconditional", {31'h0, irq}, 32'h1);
    wr(2'd1, 16'h02, 32'h08);
    @(negedge clk); perr_evt = 1'b1; @(negedge clk); perr_evt = 1'b0; #1;
    rdchk("R13 perr", 2'd1, 16'h02, 32'h10);
    chk("R9 perr unconditional", {31'h0, irq}, 32'h1);
    wr(2'd1, 16'h02, 32'h10);
    chk("R7 perr clear", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_stop();
    logic [10:0] f0;
    int ticks = 0;
    wr(2'd1, 16'h00, 32'h0000);
    rdchk("R4 halted on stop", 2'd1, 16'h02, 32'h20);
    f0 = frame_num;
    for (int i = 0; i < 3*DIV; i++) begin
      @(negedge clk); #1;
      if (frame_tick === 1'b1) ticks++;
    end
    chk("R5 no tick when stopped", ticks, 0);
    chk("R5 fnum holds", {21'h0, frame_num}, {21'h0, f0});
  endtask

  task automatic t_resume();
    @(negedge clk); resume_evt = 1'b1; @(negedge clk); resume_evt = 1'b0; #1;
    rdchk("R12 ignored cmd", 2'd1, 16'h00, 32'h0000);
    rdchk("R12 ignored sts", 2'd1, 16'h02, 32'h20);
    wr(2'd1, 16'h00, 32'h0008);
    @(negedge clk); resume_evt = 1'b1; @(negedge clk); resume_evt = 1'b0; #1;
    rdchk("R12 cmd resume", 2'd1, 16'h00, 32'h0018);
    rdchk("R12 sts resume", 2'd1, 16'h02, 32'h24);
    wr(2'd1, 16'h04, 32'h2);
    chk("R9 resume irq", {31'h0, irq}, 32'h1);
    wr(2'd1, 16'h02, 32'h04);
    chk("R7 resume clear", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_resets();
    wr(2'd1, 16'h04, 32'hF);
    wr(2'd0, 16'h0C, 32'h11);
    wr(2'd1, 16'h00, 32'h0001);
    wr(2'd1, 16'h00, 32'h0003);
    chk("R11 host no pulse", {31'h0, bus_reset_req}, 32'h0);
    rdchk("R11 host cmd", 2'd1, 16'h00, 32'h0);
    rdchk("R11 host sts", 2'd1, 16'h02, 32'h0);
    rdchk("R11 host ien", 2'd1, 16'h04, 32'h0);
    rdchk("R11 host sof", 2'd0, 16'h0C, 32'd64);
    rdchk("R11 host base", 2'd2, 16'h08, 32'h0);
    wr(2'd1, 16'h00, 32'h0005);
    chk("R11 bus reset pulse", {31'h0, bus_reset_req}, 32'h1);
    rdchk("R11 global cmd", 2'd1, 16'h00, 32'h0);
    @(negedge clk); #1;
    chk("R11 pulse one cycle", {31'h0, bus_reset_req}, 32'h0);
    for (int i = 0; i < 2*DIV; i++) @(negedge clk);
    #1;
    chk("R11 ticks stopped fnum", {21'h0, frame_num}, 32'h0);
    rdchk("R11 ticks stopped sts", 2'd1, 16'h02, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_unimpl();
    t_base();
    t_halted_fnum();
    t_run_wrap();
    t_causes();
    t_events();
    t_stop();
    t_resume();
    t_resets();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule